// File: doc/BRIEF.md
# Comparator Output Conditioning and Edge Logic

This block is the digital back end of an analog comparator. It takes the comparator's raw decision bit, which can change at any time, and first passes it through a synchronizer. It then applies two optional inversions: one that pairs with swapping the analog inputs, and one for output polarity. A selectable blanking input can freeze the result. The conditioned level is a registered status output. Each change of that level produces a one-cycle event pulse on one of two event outputs, and a single control bit chooses which edge direction goes to which output.

After the comparator is enabled, the output is held at 0 for a fixed settling time. When that time ends, a one-cycle ready pulse marks the output as valid. While the comparator is disabled, the output stays at 0 and no events are produced.

The block also picks one of two 8-bit reference codes for an external threshold DAC. The choice comes either from the conditioned output itself, which gives a window or hysteresis threshold, or from a software switch bit.

Top module: `cmp_cond_top`

## Requirements
- R1: When the exchange and polarity bits are both 0, a level held on `cmp_raw_i` appears unchanged on `cond_out_o` after the third rising clock edge that samples it: two synchronizer flops, then the output register.
- R2: When `exch_i` is 1, the conditioned output is inverted. When `pol_inv_i` is 1, it is inverted again, so with both bits at 1 the output is not inverted.
- R3: With `edge_swap_i` = 0, a 0-to-1 change of `cond_out_o` raises `out_evt_o` for one cycle, and a 1-to-0 change raises `inv_evt_o` for one cycle. Each pulse is high in the same cycle that `cond_out_o` shows its new level. The two event outputs are never high together.
- R4: With `edge_swap_i` = 1, the edge directions are exchanged: a 1-to-0 change raises `out_evt_o` and a 0-to-1 change raises `inv_evt_o`.
- R5: Bits 7:0 of `code_word_i` form code 0 and bits 23:16 form code 1. With `code_ctl_i` = 0, `ref_code_o` takes code 1 when `cond_out_o` is 1 and code 0 when it is 0. With `code_ctl_i` = 1, the choice is made by `code_sw_i` (1 selects code 1). `ref_code_o` is registered, so it shows the choice made from the previous cycle's values.
- R6: `blank_sel_i` = 0 disables blanking. A value k from 1 to 6 selects `blank_i[k-1]`, and the value 7 also disables blanking. While the selected blanking input is 1, `cond_out_o` keeps its level and neither event output pulses.
- R7: After `enable_i` rises, `ready_evt_o` pulses high exactly once, for one cycle, after the 16th rising edge (READY_CYCLES) at which `enable_i` is sampled high. Until that pulse, `cond_out_o` stays 0.
- R8: While `enable_i` is 0, `cond_out_o`, `out_evt_o`, `inv_evt_o` and `ready_evt_o` are 0 from the next edge on. A later enable restarts the settling time.
- R9: A synchronous active-high `rst` clears every output to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmp_raw_i | input | 1 | Raw, unsynchronized comparator decision |
| blank_i | input | 6 | Blanking request inputs |
| enable_i | input | 1 | Comparator enable |
| exch_i | input | 1 | Input-exchange bit; inverts the output |
| pol_inv_i | input | 1 | Output polarity invert |
| edge_swap_i | input | 1 | Swaps the edge directions of the two events |
| blank_sel_i | input | 3 | Blanking source select; 0 = none |
| code_ctl_i | input | 1 | 1 = software switch picks the code, 0 = the output picks it |
| code_sw_i | input | 1 | Software code switch |
| code_word_i | input | 24 | Code 0 at bits 7:0, code 1 at bits 23:16 |
| cond_out_o | output | 1 | Conditioned comparator output (status) |
| out_evt_o | output | 1 | Output event pulse |
| inv_evt_o | output | 1 | Inverted-output event pulse |
| ready_evt_o | output | 1 | Output-ready pulse |
| ref_code_o | output | 8 | Selected reference code |

## Verification
The hardest situation to reach is a raw edge that lands during blanking, followed by a blanking release at which the held level and the live level disagree. The event must then fire on the release edge, not on the edge where the raw bit changed. The stimulus produces this by toggling the raw bit at random while blanking inputs pulse at random under every select value from 0 to 7. A behavioural model tracks the synchronizer delay with a queue and compares every output on every cycle. Enable is also dropped in the middle of a run, which checks that the settling time restarts and that an edge present at the moment the output becomes valid produces its event.

// File: rtl/cmp_cond_pkg.sv
package cmp_cond_pkg;
  localparam int DEF_CODE_W       = 8;
  localparam int DEF_CODE1_LSB    = 16;
  localparam int DEF_NUM_BLANK    = 6;
  localparam int DEF_SYNC_STAGES  = 2;
  localparam int DEF_READY_CYCLES = 16;

  typedef enum logic {
    EDGE_DIRECT  = 1'b0,
    EDGE_SWAPPED = 1'b1
  } edge_map_e;

  typedef struct packed {
    logic out_evt;
    logic inv_evt;
  } evt_pair_t;

  function automatic evt_pair_t map_edges(edge_map_e m, logic up, logic dn);
    evt_pair_t r;
    r.out_evt = (m == EDGE_DIRECT) ? up : dn;
    r.inv_evt = (m == EDGE_DIRECT) ? dn : up;
    return r;
  endfunction
endpackage

// File: rtl/cmp_sync.sv
module cmp_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[i] <= 1'b0;
        else if (i == 0) chain_q[i] <= d_i;
        else chain_q[i] <= chain_q[(i == 0) ? 0 : i-1];
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/cmp_blank_sel.sv
module cmp_blank_sel #(
  parameter int NUM_BLANK = 6,
  localparam int SEL_W    = $clog2(NUM_BLANK + 1)
) (
  input  logic [NUM_BLANK-1:0] blank_i,
  input  logic [SEL_W-1:0]     sel_i,
  output logic                 active_o
);
  logic [NUM_BLANK-1:0] hit;

  generate
    for (genvar i = 0; i < NUM_BLANK; i++) begin : g_hit
      assign hit[i] = (sel_i == SEL_W'(i + 1)) & blank_i[i];
    end
  endgenerate

  assign active_o = |hit;
endmodule

// File: rtl/cmp_ready_timer.sv
module cmp_ready_timer #(
  parameter int CYCLES  = 16,
  localparam int CNT_W  = $clog2(CYCLES + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic enable_i,
  output logic valid_o,
  output logic ready_pulse_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !enable_i) begin
      cnt_q         <= '0;
      valid_o       <= 1'b0;
      ready_pulse_o <= 1'b0;
    end else if (!valid_o) begin
      cnt_q         <= cnt_q + 1'b1;
      valid_o       <= (cnt_q == CNT_W'(CYCLES - 1));
      ready_pulse_o <= (cnt_q == CNT_W'(CYCLES - 1));
    end else begin
      ready_pulse_o <= 1'b0;
    end
  end
endmodule

// File: rtl/cmp_cond_top.sv
module cmp_cond_top
  import cmp_cond_pkg::*;
#(
  parameter int CODE_W       = DEF_CODE_W,
  parameter int CODE1_LSB    = DEF_CODE1_LSB,
  parameter int NUM_BLANK    = DEF_NUM_BLANK,
  parameter int SYNC_STAGES  = DEF_SYNC_STAGES,
  parameter int READY_CYCLES = DEF_READY_CYCLES,
  localparam int BSEL_W      = $clog2(NUM_BLANK + 1),
  localparam int WORD_W      = CODE1_LSB + CODE_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmp_raw_i,
  input  logic [NUM_BLANK-1:0] blank_i,
  input  logic                 enable_i,
  input  logic                 exch_i,
  input  logic                 pol_inv_i,
  input  logic                 edge_swap_i,
  input  logic [BSEL_W-1:0]    blank_sel_i,
  input  logic                 code_ctl_i,
  input  logic                 code_sw_i,
  input  logic [WORD_W-1:0]    code_word_i,
  output logic                 cond_out_o,
  output logic                 out_evt_o,
  output logic                 inv_evt_o,
  output logic                 ready_evt_o,
  output logic [CODE_W-1:0]    ref_code_o
);
  logic      raw_sync;
  logic      blank_act;
  logic      valid;
  logic      cond_next;
  logic      pick_hi;
  evt_pair_t evt_next;

  cmp_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .d_i(cmp_raw_i), .q_o(raw_sync)
  );

  cmp_blank_sel #(.NUM_BLANK(NUM_BLANK)) blank_i0 (
    .blank_i(blank_i), .sel_i(blank_sel_i), .active_o(blank_act)
  );

  cmp_ready_timer #(.CYCLES(READY_CYCLES)) ready_i (
    .clk(clk), .rst(rst), .enable_i(enable_i),
    .valid_o(valid), .ready_pulse_o(ready_evt_o)
  );

  // Exchange and polarity each contribute one inversion.
  assign cond_next = raw_sync ^ exch_i ^ pol_inv_i;
  assign evt_next  = map_edges(edge_map_e'(edge_swap_i),
                               cond_next & ~cond_out_o,
                               ~cond_next & cond_out_o);

  always_ff @(posedge clk) begin
    if (rst || !enable_i || !valid) begin
      cond_out_o <= 1'b0;
      out_evt_o  <= 1'b0;
      inv_evt_o  <= 1'b0;
    end else if (blank_act) begin
      out_evt_o  <= 1'b0;
      inv_evt_o  <= 1'b0;
    end else begin
      cond_out_o <= cond_next;
      out_evt_o  <= evt_next.out_evt;
      inv_evt_o  <= evt_next.inv_evt;
    end
  end

  assign pick_hi = code_ctl_i ? code_sw_i : cond_out_o;

  always_ff @(posedge clk) begin
    if (rst) ref_code_o <= '0;
    else if (pick_hi) ref_code_o <= code_word_i[CODE1_LSB +: CODE_W];
    else ref_code_o <= code_word_i[0 +: CODE_W];
  end
endmodule

// File: rtl/cmp_cond_chk.sv
module cmp_cond_chk #(
  parameter int NUM_BLANK = 6,
  parameter int BSEL_W    = 3,
  parameter int CODE_W    = 8,
  parameter int WORD_W    = 24
) (
  input logic                 clk,
  input logic                 rst,
  input logic [NUM_BLANK-1:0] blank_i,
  input logic                 enable_i,
  input logic [BSEL_W-1:0]    blank_sel_i,
  input logic                 code_ctl_i,
  input logic                 code_sw_i,
  input logic [WORD_W-1:0]    code_word_i,
  input logic                 cond_out_o,
  input logic                 out_evt_o,
  input logic                 inv_evt_o,
  input logic                 ready_evt_o,
  input logic [CODE_W-1:0]    ref_code_o
);
  logic blank_seen;
  always_comb begin
    blank_seen = 1'b0;
    for (int k = 1; k <= NUM_BLANK; k++)
      if (int'(blank_sel_i) == k && blank_i[k-1]) blank_seen = 1'b1;
  end

  // R3
  evt_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(out_evt_o && inv_evt_o));

  // R3
  evt_on_change_chk: assert property (@(posedge clk) disable iff (rst)
    (out_evt_o || inv_evt_o) |-> (cond_out_o != $past(cond_out_o)));

  // R6
  blank_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (blank_seen && enable_i) |=> ($stable(cond_out_o) && !out_evt_o && !inv_evt_o));

  // R8
  disabled_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !enable_i |=> (!cond_out_o && !out_evt_o && !inv_evt_o && !ready_evt_o));

  // R7
  ready_single_chk: assert property (@(posedge clk) disable iff (rst)
    ready_evt_o |=> !ready_evt_o);

  // R5
  code_sw_low_chk: assert property (@(posedge clk) disable iff (rst)
    (code_ctl_i && !code_sw_i) |=> (ref_code_o == $past(code_word_i[CODE_W-1:0])));
endmodule

bind cmp_cond_top cmp_cond_chk #(
  .NUM_BLANK(NUM_BLANK), .BSEL_W(BSEL_W), .CODE_W(CODE_W), .WORD_W(WORD_W)
) chk_i (
  .clk(clk), .rst(rst), .blank_i(blank_i), .enable_i(enable_i),
  .blank_sel_i(blank_sel_i), .code_ctl_i(code_ctl_i), .code_sw_i(code_sw_i),
  .code_word_i(code_word_i), .cond_out_o(cond_out_o), .out_evt_o(out_evt_o),
  .inv_evt_o(inv_evt_o), .ready_evt_o(ready_evt_o), .ref_code_o(ref_code_o)
);

// File: tb/cmp_cond_top_tb_top.sv
`timescale 1ns/1ps
module cmp_cond_top_tb_top;
  localparam int READY_N = 16;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmp_raw_i = 1'b0;
  logic [5:0]  blank_i = '0;
  logic        enable_i = 1'b0;
  logic        exch_i = 1'b0;
  logic        pol_inv_i = 1'b0;
  logic        edge_swap_i = 1'b0;
  logic [2:0]  blank_sel_i = '0;
  logic        code_ctl_i = 1'b0;
  logic        code_sw_i = 1'b0;
  logic [23:0] code_word_i = 24'hA5_00_3C;
  logic        cond_out_o, out_evt_o, inv_evt_o, ready_evt_o;
  logic [7:0]  ref_code_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2 clk = ~clk;

  cmp_cond_top dut_i (
    .clk(clk), .rst(rst), .cmp_raw_i(cmp_raw_i), .blank_i(blank_i),
    .enable_i(enable_i), .exch_i(exch_i), .pol_inv_i(pol_inv_i),
    .edge_swap_i(edge_swap_i), .blank_sel_i(blank_sel_i),
    .code_ctl_i(code_ctl_i), .code_sw_i(code_sw_i), .code_word_i(code_word_i),
    .cond_out_o(cond_out_o), .out_evt_o(out_evt_o), .inv_evt_o(inv_evt_o),
    .ready_evt_o(ready_evt_o), .ref_code_o(ref_code_o)
  );

  // Behavioural reference model
  bit sync_q[$];
  bit m_out, m_oe, m_ie, m_rdy, m_valid, m_blank;
  int m_cnt;
  int m_code;

  initial begin sync_q.push_back(0); sync_q.push_back(0); end

  always @(posedge clk) begin
    bit lvl, blank, hi;
    if (rst) begin
      sync_q = {}; sync_q.push_back(0); sync_q.push_back(0);
      m_out = 0; m_oe = 0; m_ie = 0; m_rdy = 0; m_valid = 0; m_cnt = 0; m_code = 0;
    end else begin
      lvl = sync_q[0] ^ exch_i ^ pol_inv_i;
      void'(sync_q.pop_front());
      sync_q.push_back(cmp_raw_i);
      blank = (blank_sel_i >= 1 && blank_sel_i <= 6) ? blank_i[blank_sel_i - 1] : 1'b0;
      hi = code_ctl_i ? code_sw_i : m_out;
      m_code = hi ? int'(code_word_i[23:16]) : int'(code_word_i[7:0]);
      m_oe = 0; m_ie = 0; m_rdy = 0;
      if (!enable_i) begin
        m_out = 0; m_valid = 0; m_cnt = 0;
      end else if (!m_valid) begin
        m_cnt++;
        if (m_cnt == READY_N) begin m_valid = 1; m_rdy = 1; end
      end else if (!blank && lvl != m_out) begin
        if (lvl ^ edge_swap_i) m_oe = 1; else m_ie = 1;
        m_out = lvl;
      end
    end
    m_blank = blank_i[0] | blank_i[1] | blank_i[2] | blank_i[3] | blank_i[4] | blank_i[5];
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // Per-cycle compare, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      check((exch_i | pol_inv_i) ? "R2 cond_out" : (!enable_i ? "R8 cond_out" : "R1 cond_out"),
            cond_out_o, m_out);
      check(m_blank && blank_sel_i != 0 ? "R6 out_evt" : (edge_swap_i ? "R4 out_evt" : "R3 out_evt"),
            out_evt_o, m_oe);
      check(edge_swap_i ? "R4 inv_evt" : "R3 inv_evt", inv_evt_o, m_ie);
      check("R7 ready_evt", ready_evt_o, m_rdy);
      check("R5 ref_code", ref_code_o, m_code);
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    cyc(4);
    // R9: reset state
    check("R9 cond_out", cond_out_o, 0);
    check("R9 events", {out_evt_o, inv_evt_o, ready_evt_o}, 0);
    check("R9 ref_code", ref_code_o, 0);
    rst = 1'b0;
    enable_i = 1'b1;
    cmp_raw_i = 1'b1;
    cyc(READY_N + 4);                 // R7 settling, then R1 edge on valid
    cmp_raw_i = 1'b0; cyc(6);
    cmp_raw_i = 1'b1; cyc(6);
    exch_i = 1'b1; cyc(6);            // R2 single inversion
    pol_inv_i = 1'b1; cyc(6);         // R2 double inversion
    edge_swap_i = 1'b1;               // R4
    cmp_raw_i = 1'b0; cyc(6);
    cmp_raw_i = 1'b1; cyc(6);
    code_ctl_i = 1'b1; code_sw_i = 1'b1; cyc(3);  // R5 software pick
    code_sw_i = 1'b0; cyc(3);
    code_ctl_i = 1'b0;
    // R6: each select value with all blanking inputs active
    for (int s = 0; s < 8; s++) begin
      blank_sel_i = 3'(s); blank_i = 6'h3F;
      cmp_raw_i = ~cmp_raw_i; cyc(6);
      blank_i = 6'h00; cyc(6);
    end
    enable_i = 1'b0; cyc(5);          // R8
    enable_i = 1'b1; cyc(READY_N + 5);
    // Random phase
    for (int i = 0; i < 6000; i++) begin
      if ($urandom_range(0, 3) == 0) cmp_raw_i = ~cmp_raw_i;
      if ($urandom_range(0, 7) == 0) blank_i = 6'($urandom);
      else if ($urandom_range(0, 3) == 0) blank_i = '0;
      if ($urandom_range(0, 99) == 0) begin
        exch_i = 1'($urandom); pol_inv_i = 1'($urandom);
        edge_swap_i = 1'($urandom); blank_sel_i = 3'($urandom);
        code_ctl_i = 1'($urandom); code_word_i = 24'($urandom);
      end
      if ($urandom_range(0, 15) == 0) code_sw_i = ~code_sw_i;
      if ($urandom_range(0, 399) == 0) enable_i = ~enable_i;
      cyc(1);
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule